// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block follows the active-lane mask of one 32-lane warp as the warp runs through branches. All lanes share one fetched instruction, so when the active lanes disagree on a branch the two paths must be run one after the other. The block runs the taken lanes first. It stores the lanes still waiting, where they resume, and the point where the paths meet again in a small last-in-first-out stack. When the running path reaches that meeting point, the block switches to the waiting lanes. When the waiting lanes reach it too, the block restores the mask the warp had before the branch.

A branch on which every active lane agrees costs nothing: only that path runs, and nothing is stored. Lanes that are masked off never run, so each lane still follows its own correct path. A warp is started with a launch mask. For the last warp of a thread group whose size is not a multiple of 32, that mask leaves the unused lanes off from the start. If the warp nests more divergent branches than the stack can hold, the block raises a sticky overflow flag and freezes until the next launch.

The control is a three-state machine. **IDLE** is entered at reset. **RUN** is where the warp executes. **FAULT** is entered on overflow. The transitions are:
- *start*: IDLE to RUN on launch.
- *restart*: RUN to RUN on launch.
- *spill*: RUN to FAULT on a divergent branch while the stack is full.
- *recover*: FAULT to RUN on launch.
- *reset*: any state to IDLE.

Top module: `simt_div_stack`

## Requirements
- R1: After reset, active_mask is 0, next_pc is 0 and overflow is 0. Until the first launch, the issue and branch inputs have no effect on the outputs.
- R2: A launch in any state loads active_mask from launch_mask and next_pc from launch_pc, clears overflow and empties the stack, one cycle later. Lanes outside the launch mask never become active before the next launch.
- R3: An issue with no branch and no reconvergence sets next_pc to cur_pc + 4 and leaves active_mask unchanged.
- R4: At a branch the effective taken set is br_taken AND active_mask, so taken bits of inactive lanes are ignored. If that set equals active_mask, next_pc becomes br_target. If it is empty, next_pc becomes br_fallthru. In both cases the mask is unchanged and nothing is pushed.
- R5: On a divergent branch (effective taken set neither empty nor equal to active_mask), the block pushes an entry and sets active_mask to the effective taken set and next_pc to br_target. The entry holds the not-taken lanes, br_fallthru, br_reconv and the mask the warp had before the branch.
- R6: When an issued cur_pc equals the reconvergence PC of the top entry and that entry has not yet been resumed, active_mask becomes the entry's not-taken lanes and next_pc its fall-through PC. The entry stays on the stack, marked as resumed.
- R7: When an issued cur_pc equals the reconvergence PC of a resumed top entry, the entry is popped, active_mask returns to the mask saved before the branch and next_pc becomes the reconvergence PC.
- R8: Reconvergence takes priority over a branch issued in the same cycle: the branch inputs are ignored in that cycle.
- R9: Nested divergence is unwound innermost first. The stack holds 8 entries.
- R10: A divergent branch when 8 entries are held sets overflow and enters FAULT. In FAULT, active_mask and next_pc hold and issued instructions are ignored.
- R11: overflow stays set until the next launch or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch | input | 1 | Start or restart the warp |
| launch_mask | input | 32 | Initial lane mask; bit n is lane n |
| launch_pc | input | 32 | Initial program counter |
| issue | input | 1 | An instruction at cur_pc is issued this cycle |
| cur_pc | input | 32 | PC of the issued instruction |
| br_valid | input | 1 | The issued instruction is a branch |
| br_taken | input | 32 | Per-lane branch outcome; bit n is lane n |
| br_target | input | 32 | PC of the taken path |
| br_fallthru | input | 32 | PC of the not-taken path |
| br_reconv | input | 32 | PC where both paths meet again |
| active_mask | output | 32 | Lanes enabled for the next instruction |
| next_pc | output | 32 | PC the warp fetches next |
| overflow | output | 1 | Sticky flag: a push found the stack full |

## Verification
The bench targets the two visits to a reconvergence point. A design that pops on the first visit would never run the not-taken lanes. A design that never marks the entry as resumed would bounce between the two paths forever. A branch issued at the reconvergence PC checks the priority rule, because a design that serves the branch first would push a spurious entry and jump away. Partial warps are exercised with taken bits set only on inactive lanes: a design that skips the AND with the active mask would see a false divergence and wake lanes that do not exist. The ninth nested split checks that the overflow flag and the freeze appear exactly at the full stack and not one entry early. A launch afterwards checks that stale entries are discarded.

// File: rtl/simt_div_pkg.sv
`timescale 1ns/1ps
package simt_div_pkg;

    localparam int LANES       = 32;
    localparam int PC_W        = 32;
    localparam int STACK_DEPTH = 8;
    localparam int PC_STEP     = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } div_state_e;

    typedef enum logic [1:0] {
        BR_NONE  = 2'd0,
        BR_ALL   = 2'd1,
        BR_SPLIT = 2'd2
    } br_kind_e;

    // One divergence record: lanes still waiting, mask to restore, where the
    // waiting lanes resume, where both paths meet, and whether they resumed.
    typedef struct packed {
        logic [LANES-1:0] pend_mask;
        logic [LANES-1:0] join_mask;
        logic [PC_W-1:0]  resume_pc;
        logic [PC_W-1:0]  reconv_pc;
        logic             resumed;
    } stk_entry_t;

endpackage

// File: rtl/simt_branch_eval.sv
`timescale 1ns/1ps
module simt_branch_eval
    import simt_div_pkg::*;
#(
    parameter int N_LANES = LANES
) (
    input  logic [N_LANES-1:0] cur_mask,
    input  logic [N_LANES-1:0] taken,
    output logic [N_LANES-1:0] go_mask,
    output logic [N_LANES-1:0] stay_mask,
    output br_kind_e           kind
);

    // Per-lane split of the active lanes into taken and not-taken sets.
    for (genvar ln = 0; ln < N_LANES; ln++) begin : g_lane
        assign go_mask[ln]   = cur_mask[ln] &  taken[ln];
        assign stay_mask[ln] = cur_mask[ln] & ~taken[ln];
    end

    always_comb begin
        if (go_mask == '0) begin
            kind = BR_NONE;
        end else if (stay_mask == '0) begin
            kind = BR_ALL;
        end else begin
            kind = BR_SPLIT;
        end
    end

endmodule

// File: rtl/simt_mask_lifo.sv
`timescale 1ns/1ps
module simt_mask_lifo
    import simt_div_pkg::*;
#(
    parameter int DEPTH = STACK_DEPTH
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear,
    input  logic                           push,
    input  logic                           pop,
    input  logic                           mark_resumed,
    input  stk_entry_t                     push_entry,
    output stk_entry_t                     top_entry,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           empty,
    output logic                           full
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] DEPTH_V = CNT_W'(DEPTH);

    stk_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] top_idx;
    logic [PTR_W-1:0] wr_idx;

    assign top_idx   = PTR_W'(count - CNT_W'(1));
    assign wr_idx    = PTR_W'(count);
    assign empty     = (count == '0);
    assign full      = (count == DEPTH_V);
    assign top_entry = mem[top_idx];

    always_ff @(posedge clk) begin
        if (!clear) begin
            if (push && !full) begin
                mem[wr_idx] <= push_entry;
            end else if (mark_resumed && !empty) begin
                mem[top_idx].resumed <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (push && !full) begin
            count <= count + CNT_W'(1);
        end else if (pop && !empty) begin
            count <= count - CNT_W'(1);
        end
    end

endmodule

// File: rtl/simt_div_stack.sv
`timescale 1ns/1ps
module simt_div_stack
    import simt_div_pkg::*;
#(
    parameter int DEPTH = STACK_DEPTH,
    parameter int STEP  = PC_STEP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [LANES-1:0] launch_mask,
    input  logic [PC_W-1:0]  launch_pc,
    input  logic             issue,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic             br_valid,
    input  logic [LANES-1:0] br_taken,
    input  logic [PC_W-1:0]  br_target,
    input  logic [PC_W-1:0]  br_fallthru,
    input  logic [PC_W-1:0]  br_reconv,
    output logic [LANES-1:0] active_mask,
    output logic [PC_W-1:0]  next_pc,
    output logic             overflow
);

    localparam int              CNT_W  = $clog2(DEPTH + 1);
    localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

    div_state_e       state_q, state_d;
    logic [LANES-1:0] mask_q;
    logic [PC_W-1:0]  pc_q;
    logic             ovf_q;

    logic [LANES-1:0] go_mask, stay_mask;
    br_kind_e         kind;

    stk_entry_t       stk_top, stk_new;
    logic [CNT_W-1:0] stk_count;
    logic             stk_empty, stk_full;
    logic             stk_push, stk_pop, stk_mark;

    logic             running, rejoin, do_branch, do_split, do_spill;

    simt_branch_eval #(.N_LANES(LANES)) u_eval (
        .cur_mask  (mask_q),
        .taken     (br_taken),
        .go_mask   (go_mask),
        .stay_mask (stay_mask),
        .kind      (kind)
    );

    simt_mask_lifo #(.DEPTH(DEPTH)) u_lifo (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (launch),
        .push         (stk_push),
        .pop          (stk_pop),
        .mark_resumed (stk_mark),
        .push_entry   (stk_new),
        .top_entry    (stk_top),
        .count        (stk_count),
        .empty        (stk_empty),
        .full         (stk_full)
    );

    // Decode of the issued instruction against the stack top.
    assign running   = (state_q == ST_RUN);
    assign rejoin    = running && issue && !stk_empty && (cur_pc == stk_top.reconv_pc);
    assign do_branch = running && issue && !rejoin && br_valid;
    assign do_split  = do_branch && (kind == BR_SPLIT);
    assign do_spill  = do_split && stk_full;

    assign stk_push  = do_split && !stk_full && !launch;
    assign stk_pop   = rejoin &&  stk_top.resumed && !launch;
    assign stk_mark  = rejoin && !stk_top.resumed && !launch;

    always_comb begin
        stk_new.pend_mask = stay_mask;
        stk_new.join_mask = mask_q;
        stk_new.resume_pc = br_fallthru;
        stk_new.reconv_pc = br_reconv;
        stk_new.resumed   = 1'b0;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: start, restart, spill, recover
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (launch) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (launch)        state_d = ST_RUN;
                else if (do_spill) state_d = ST_FAULT;
            end
            ST_FAULT: begin
                if (launch) state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            pc_q   <= '0;
            ovf_q  <= 1'b0;
        end else if (launch) begin
            mask_q <= launch_mask;
            pc_q   <= launch_pc;
            ovf_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (rejoin) begin
                        if (stk_top.resumed) begin
                            mask_q <= stk_top.join_mask;
                            pc_q   <= stk_top.reconv_pc;
                        end else begin
                            mask_q <= stk_top.pend_mask;
                            pc_q   <= stk_top.resume_pc;
                        end
                    end else if (do_branch) begin
                        unique case (kind)
                            BR_ALL:  pc_q <= br_target;
                            BR_NONE: pc_q <= br_fallthru;
                            BR_SPLIT: begin
                                if (stk_full) begin
                                    ovf_q <= 1'b1;
                                end else begin
                                    mask_q <= go_mask;
                                    pc_q   <= br_target;
                                end
                            end
                            default: ;
                        endcase
                    end else if (issue) begin
                        pc_q <= cur_pc + STEP_V;
                    end
                end
                ST_IDLE, ST_FAULT: ;
                default: ;
            endcase
        end
    end

    assign active_mask = mask_q;
    assign next_pc     = pc_q;
    assign overflow    = ovf_q;

endmodule

// File: rtl/simt_div_stack_chk.sv
`timescale 1ns/1ps
module simt_div_stack_chk
    import simt_div_pkg::*;
#(
    parameter int DEPTH = STACK_DEPTH
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       launch,
    input logic [LANES-1:0]           launch_mask,
    input logic [PC_W-1:0]            launch_pc,
    input logic                       issue,
    input logic                       br_valid,
    input logic [LANES-1:0]           br_taken,
    input logic [PC_W-1:0]            br_target,
    input logic [LANES-1:0]           active_mask,
    input logic [PC_W-1:0]            next_pc,
    input logic                       overflow,
    input logic [$clog2(DEPTH+1)-1:0] depth,
    input div_state_e                 state
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] DEPTH_V = CNT_W'(DEPTH);

    logic [LANES-1:0] lmask_q;
    logic [LANES-1:0] eff;
    logic             plain_run;

    always_ff @(posedge clk) begin
        if (!rst_n)      lmask_q <= '0;
        else if (launch) lmask_q <= launch_mask;
    end

    assign eff       = br_taken & active_mask;
    assign plain_run = (state == ST_RUN) && issue && br_valid && !launch && (depth == '0);

    // R2
    launch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (active_mask == $past(launch_mask)) && (next_pc == $past(launch_pc))
                   && !overflow && (depth == '0));

    // R2
    lane_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_mask & ~lmask_q) == '0);

    // R4
    uniform_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_run && ((eff == active_mask) || (eff == '0)))
        |=> $stable(active_mask) && (depth == '0));

    // R5
    split_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_run && (eff != active_mask) && (eff != '0))
        |=> (active_mask == $past(eff)) && (depth == CNT_W'(1)) && (next_pc == $past(br_target)));

    // R9
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= DEPTH_V);

    // R10
    fault_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_FAULT) && !launch) |=> $stable(active_mask) && $stable(next_pc));

    // R11
    no_overflow_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !launch) |=> overflow);

endmodule

bind simt_div_stack simt_div_stack_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch),
    .launch_mask (launch_mask),
    .launch_pc   (launch_pc),
    .issue       (issue),
    .br_valid    (br_valid),
    .br_taken    (br_taken),
    .br_target   (br_target),
    .active_mask (active_mask),
    .next_pc     (next_pc),
    .overflow    (overflow),
    .depth       (stk_count),
    .state       (state_q)
);

// File: tb/tb_simt_div_stack.sv
`timescale 1ns/1ps
module tb_simt_div_stack;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        launch = 1'b0;
    logic [31:0] launch_mask = '0;
    logic [31:0] launch_pc = '0;
    logic        issue = 1'b0;
    logic [31:0] cur_pc = '0;
    logic        br_valid = 1'b0;
    logic [31:0] br_taken = '0;
    logic [31:0] br_target = '0;
    logic [31:0] br_fallthru = '0;
    logic [31:0] br_reconv = '0;
    logic [31:0] active_mask;
    logic [31:0] next_pc;
    logic        overflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    simt_div_stack dut (
        .clk(clk), .rst_n(rst_n), .launch(launch), .launch_mask(launch_mask),
        .launch_pc(launch_pc), .issue(issue), .cur_pc(cur_pc), .br_valid(br_valid),
        .br_taken(br_taken), .br_target(br_target), .br_fallthru(br_fallthru),
        .br_reconv(br_reconv), .active_mask(active_mask), .next_pc(next_pc),
        .overflow(overflow)
    );

    // Row: launch, issue, brv, msk(32), cpc, tgt, fth, rcv (16 each), exp mask(32), exp pc(16), exp ovf
    localparam int NV = 22;
    localparam logic [147:0] VEC [NV] = '{
        {3'b100, 32'hFFFFFFFF, 16'h0100, 16'h0000, 16'h0000, 16'h0000, 32'hFFFFFFFF, 16'h0100, 1'b0}, // R2
        {3'b010, 32'h00000000, 16'h0100, 16'h0000, 16'h0000, 16'h0000, 32'hFFFFFFFF, 16'h0104, 1'b0}, // R3
        {3'b011, 32'hFFFFFFFF, 16'h0104, 16'h0200, 16'h0108, 16'h0300, 32'hFFFFFFFF, 16'h0200, 1'b0}, // R4 all
        {3'b011, 32'h00000000, 16'h0200, 16'h0400, 16'h0204, 16'h0500, 32'hFFFFFFFF, 16'h0204, 1'b0}, // R4 none
        {3'b011, 32'h0000FFFF, 16'h0204, 16'h0240, 16'h0208, 16'h0280, 32'h0000FFFF, 16'h0240, 1'b0}, // R5
        {3'b010, 32'h00000000, 16'h0240, 16'h0000, 16'h0000, 16'h0000, 32'h0000FFFF, 16'h0244, 1'b0}, // R3
        {3'b011, 32'hFFFFFFFF, 16'h0280, 16'h0999, 16'h0998, 16'h0997, 32'hFFFF0000, 16'h0208, 1'b0}, // R8 R6
        {3'b010, 32'h00000000, 16'h0208, 16'h0000, 16'h0000, 16'h0000, 32'hFFFF0000, 16'h020C, 1'b0}, // R3
        {3'b010, 32'h00000000, 16'h0280, 16'h0000, 16'h0000, 16'h0000, 32'hFFFFFFFF, 16'h0280, 1'b0}, // R7
        {3'b010, 32'h00000000, 16'h0280, 16'h0000, 16'h0000, 16'h0000, 32'hFFFFFFFF, 16'h0284, 1'b0}, // R7 popped
        {3'b100, 32'h000000FF, 16'h0010, 16'h0000, 16'h0000, 16'h0000, 32'h000000FF, 16'h0010, 1'b0}, // R2 partial
        {3'b011, 32'hFFFFFF00, 16'h0010, 16'h0040, 16'h0014, 16'h0050, 32'h000000FF, 16'h0014, 1'b0}, // R4 masked
        {3'b011, 32'hFFFFFFFF, 16'h0014, 16'h0060, 16'h0018, 16'h0070, 32'h000000FF, 16'h0060, 1'b0}, // R4
        {3'b011, 32'h0000000F, 16'h0060, 16'h0080, 16'h0064, 16'h0090, 32'h0000000F, 16'h0080, 1'b0}, // R5
        {3'b011, 32'h00000003, 16'h0080, 16'h0088, 16'h0084, 16'h008C, 32'h00000003, 16'h0088, 1'b0}, // R9
        {3'b010, 32'h00000000, 16'h008C, 16'h0000, 16'h0000, 16'h0000, 32'h0000000C, 16'h0084, 1'b0}, // R9 R6
        {3'b010, 32'h00000000, 16'h0084, 16'h0000, 16'h0000, 16'h0000, 32'h0000000C, 16'h0088, 1'b0}, // R3
        {3'b010, 32'h00000000, 16'h008C, 16'h0000, 16'h0000, 16'h0000, 32'h0000000F, 16'h008C, 1'b0}, // R9 R7
        {3'b010, 32'h00000000, 16'h008C, 16'h0000, 16'h0000, 16'h0000, 32'h0000000F, 16'h0090, 1'b0}, // R9
        {3'b010, 32'h00000000, 16'h0090, 16'h0000, 16'h0000, 16'h0000, 32'h000000F0, 16'h0064, 1'b0}, // R6
        {3'b010, 32'h00000000, 16'h0090, 16'h0000, 16'h0000, 16'h0000, 32'h000000FF, 16'h0090, 1'b0}, // R7
        {3'b000, 32'h00000000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 32'h000000FF, 16'h0090, 1'b0}  // R3 idle
    };
    localparam int ROW_REQ [NV] = '{2, 3, 4, 4, 5, 3, 8, 3, 7, 7, 2, 4, 4, 5, 9, 6, 3, 7, 9, 6, 7, 3};

    task automatic drive(input logic l, input logic [31:0] m, input logic [31:0] pc,
                         input logic is, input logic bv, input logic [31:0] tgt,
                         input logic [31:0] fth, input logic [31:0] rcv);
        @(negedge clk);
        launch      = l;
        launch_mask = m;
        launch_pc   = pc;
        issue       = is;
        cur_pc      = pc;
        br_valid    = bv;
        br_taken    = m;
        br_target   = tgt;
        br_fallthru = fth;
        br_reconv   = rcv;
        @(posedge clk);
        #2;
    endtask

    task automatic check(input int req, input logic [31:0] em, input logic [31:0] ep, input logic eo);
        checks++;
        if (active_mask !== em || next_pc !== ep || overflow !== eo) begin
            fails++;
            $display("FAIL R%0d: mask=%h pc=%h ovf=%b expected mask=%h pc=%h ovf=%b",
                     req, active_mask, next_pc, overflow, em, ep, eo);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        logic [147:0] r;
        // R1: reset state
        repeat (2) @(posedge clk);
        #2;
        check(1, 32'h0, 32'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: issue and branch before launch have no effect
        drive(1'b0, 32'h0000FFFF, 32'h00000040, 1'b1, 1'b1, 32'h80, 32'h44, 32'h90);
        check(1, 32'h0, 32'h0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            r = VEC[i];
            drive(r[147], r[144:113], {16'h0, r[112:97]}, r[146], r[145],
                  {16'h0, r[96:81]}, {16'h0, r[80:65]}, {16'h0, r[64:49]});
            check(ROW_REQ[i], r[48:17], {16'h0, r[16:1]}, r[0]);
        end

        // R9 R5: eight nested splits fill the stack
        drive(1'b1, 32'hFFFFFFFF, 32'h1000, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0);
        check(2, 32'hFFFFFFFF, 32'h1000, 1'b0);
        for (int k = 0; k < 8; k++) begin
            drive(1'b0, 32'hFFFFFFFF >> (k + 1), 32'h3000 + 32'(k * 4), 1'b1, 1'b1,
                  32'h4000 + 32'(k * 4), 32'h5000 + 32'(k * 4), 32'h2000 + 32'(k * 4));
            check(9, 32'hFFFFFFFF >> (k + 1), 32'h4000 + 32'(k * 4), 1'b0);
        end
        // R10: ninth split overflows, mask and pc hold
        drive(1'b0, 32'hFFFFFFFF >> 10, 32'h3100, 1'b1, 1'b1, 32'h6000, 32'h6004, 32'h6008);
        check(10, 32'h00FFFFFF, 32'h401C, 1'b1);
        // R10 R11: frozen and sticky in the fault state
        drive(1'b0, 32'h0, 32'h3200, 1'b1, 1'b0, 32'h0, 32'h0, 32'h0);
        check(11, 32'h00FFFFFF, 32'h401C, 1'b1);
        // R11 R2: launch clears the flag
        drive(1'b1, 32'h0000000F, 32'h0020, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0);
        check(11, 32'h0000000F, 32'h0020, 1'b0);
        // R2: stale entries are gone, so an old reconvergence PC is ordinary code
        drive(1'b0, 32'h0, 32'h201C, 1'b1, 1'b0, 32'h0, 32'h0, 32'h0);
        check(2, 32'h0000000F, 32'h2020, 1'b0);

        // R1: reset during operation
        @(negedge clk);
        rst_n = 1'b0;
        issue = 1'b0;
        @(posedge clk);
        #2;
        check(1, 32'h0, 32'h0, 1'b0);
        finish_run();
    end

endmodule